// File: doc/BRIEF.md
# Out-of-order issue window with tag-to-register wakeup

This block holds renamed instructions between rename and execution. Each entry has two source fields and one destination virtual tag. A source field has its own ready bit. While that bit is 0, the field holds the virtual tag of the producer the source waits on. Once the bit is 1, the field holds the physical register number where the operand lives. The destination virtual tag is kept so that it can go with the instruction when it issues.

When a producer reaches its last execution cycle and has been given a physical register, it sends a writeback broadcast. The broadcast carries the producer's virtual tag and the new physical register number. Every waiting source whose tag matches becomes ready, and its field is rewritten with the physical register number. An issued entry therefore names its operands directly in the physical register file.

The window keeps its occupied slots packed at the low end, in age order, so slot 0 is always the oldest entry. Each cycle it issues the oldest entry whose two sources are both ready. A flush empties the window in a single cycle.

Top module: `issue_window`

## Requirements
- R1: After reset the window is empty: `issue_valid` is 0 and `disp_ready` is 1.
- R2: An entry dispatched with both sources ready (`disp_rdy0`/`disp_rdy1` = 1) appears on the issue outputs in the cycle after dispatch. Its fields are carried unchanged: `issue_src0` and `issue_src1` take the low `PREG_W` bits of the source fields, and `issue_dst` takes the destination tag. The entry then leaves the window at the next clock edge.
- R3: An entry with a waiting source does not issue. A broadcast whose `bc_vtag` equals the low `VTAG_W` bits of that waiting field sets the ready bit and replaces the field with `bc_preg`. The new physical number shows on the issue outputs from the next cycle.
- R4: A broadcast whose tag matches no waiting source changes nothing, and a blocked entry stays blocked.
- R5: A broadcast in the same cycle as a dispatch wakes a matching waiting source of the entry being dispatched.
- R6: At most one entry issues per cycle. When several entries are ready, the one in the lowest slot (the oldest) issues first. Later entries issue in dispatch order.
- R7: `flush` empties the window at the next edge. A dispatch presented in the same cycle is dropped. Broadcasts after the flush bring none of the flushed entries back.
- R8: With all `DEPTH` slots occupied, `disp_ready` is 0 and a dispatch is ignored.
- R9: A source that is already ready is never changed by a broadcast, even when its physical number equals the broadcast tag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the whole window |
| disp_valid | input | 1 | Dispatch request from rename |
| disp_rdy0 | input | 1 | Source 0 ready (field holds a physical number) |
| disp_fld0 | input | FIELD_W | Source 0 virtual tag or physical number |
| disp_rdy1 | input | 1 | Source 1 ready |
| disp_fld1 | input | FIELD_W | Source 1 virtual tag or physical number |
| disp_dst | input | VTAG_W | Destination virtual tag |
| disp_ready | output | 1 | Window has a free slot |
| bc_valid | input | 1 | Writeback broadcast valid |
| bc_vtag | input | VTAG_W | Virtual tag of the producer |
| bc_preg | input | PREG_W | Physical register bound to that tag |
| issue_valid | output | 1 | An entry issues this cycle |
| issue_src0 | output | PREG_W | Physical register of source 0 |
| issue_src1 | output | PREG_W | Physical register of source 1 |
| issue_dst | output | VTAG_W | Destination virtual tag of the issued entry |

## Verification
The assertions check four things on every cycle: the occupied slots stay packed as a prefix, an issued entry has both sources ready, no lower slot is ready when a higher one issues, and a flush or a full window never adds an entry. Only the bench scenarios can show that a wakeup rewrites the field with the broadcast number. The same holds for same-cycle dispatch wakeup, for an unmatched tag or an already-ready source being left alone, and for the exact dispatch-to-issue order through a full window.

// File: rtl/iw_pkg.sv
package iw_pkg;

    function automatic int iw_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/iw_src_wake.sv
module iw_src_wake #(
    parameter int VTAG_W  = 6,
    parameter int PREG_W  = 5,
    parameter int FIELD_W = 6
) (
    input  logic               rdy_i,
    input  logic [FIELD_W-1:0] fld_i,
    input  logic               bc_valid,
    input  logic [VTAG_W-1:0]  bc_vtag,
    input  logic [PREG_W-1:0]  bc_preg,
    output logic               rdy_o,
    output logic [FIELD_W-1:0] fld_o
);
    logic hit;

    // Only a waiting source compares its tag against the broadcast.
    always_comb begin
        hit   = bc_valid && !rdy_i && (fld_i[VTAG_W-1:0] == bc_vtag);
        rdy_o = rdy_i || hit;
        fld_o = hit ? FIELD_W'(bc_preg) : fld_i;
    end
endmodule

// File: rtl/iw_pick.sv
module iw_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Lowest index wins: slot 0 is the oldest entry.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/issue_window.sv
module issue_window #(
    parameter int DEPTH  = 8,
    parameter int VTAG_W = 6,
    parameter int PREG_W = 5,
    parameter int FIELD_W = iw_pkg::iw_max(VTAG_W, PREG_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               disp_valid,
    input  logic               disp_rdy0,
    input  logic [FIELD_W-1:0] disp_fld0,
    input  logic               disp_rdy1,
    input  logic [FIELD_W-1:0] disp_fld1,
    input  logic [VTAG_W-1:0]  disp_dst,
    output logic               disp_ready,
    input  logic               bc_valid,
    input  logic [VTAG_W-1:0]  bc_vtag,
    input  logic [PREG_W-1:0]  bc_preg,
    output logic               issue_valid,
    output logic [PREG_W-1:0]  issue_src0,
    output logic [PREG_W-1:0]  issue_src1,
    output logic [VTAG_W-1:0]  issue_dst
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NSRC  = 2 * DEPTH + 2;
    localparam int DSRC  = 2 * DEPTH;

    typedef struct packed {
        logic [FIELD_W-1:0] f0;
        logic [FIELD_W-1:0] f1;
        logic               r0;
        logic               r1;
        logic [VTAG_W-1:0]  dst;
    } ent_t;

    typedef struct packed {
        logic [DEPTH-1:0]  vld;
        ent_t [DEPTH-1:0]  ent;
    } state_t;

    state_t st_d, st_q;

    logic               cur_rdy [NSRC];
    logic [FIELD_W-1:0] cur_fld [NSRC];
    logic               wk_rdy  [NSRC];
    logic [FIELD_W-1:0] wk_fld  [NSRC];

    logic [DEPTH-1:0] req;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;

    // Gather every source field: stored entries, then the dispatch slot.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cur_rdy[2*i]   = st_q.ent[i].r0;
            cur_fld[2*i]   = st_q.ent[i].f0;
            cur_rdy[2*i+1] = st_q.ent[i].r1;
            cur_fld[2*i+1] = st_q.ent[i].f1;
        end
        cur_rdy[DSRC]   = disp_rdy0;
        cur_fld[DSRC]   = disp_fld0;
        cur_rdy[DSRC+1] = disp_rdy1;
        cur_fld[DSRC+1] = disp_fld1;
    end

    for (genvar j = 0; j < NSRC; j++) begin : g_wake
        iw_src_wake #(
            .VTAG_W (VTAG_W),
            .PREG_W (PREG_W),
            .FIELD_W(FIELD_W)
        ) u_wake (
            .rdy_i   (cur_rdy[j]),
            .fld_i   (cur_fld[j]),
            .bc_valid(bc_valid),
            .bc_vtag (bc_vtag),
            .bc_preg (bc_preg),
            .rdy_o   (wk_rdy[j]),
            .fld_o   (wk_fld[j])
        );
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            req[i] = st_q.vld[i] && st_q.ent[i].r0 && st_q.ent[i].r1;
        end
    end

    iw_pick #(
        .N    (DEPTH),
        .IDX_W(IDX_W)
    ) u_pick (
        .req(req),
        .any(pick_any),
        .idx(pick_idx)
    );

    assign disp_ready  = !st_q.vld[DEPTH-1];
    assign issue_valid = pick_any;
    assign issue_src0  = st_q.ent[pick_idx].f0[PREG_W-1:0];
    assign issue_src1  = st_q.ent[pick_idx].f1[PREG_W-1:0];
    assign issue_dst   = st_q.ent[pick_idx].dst;

    // Next state: remove the issued slot, shift the younger ones down,
    // apply wakeup, then append the dispatched entry at the first hole.
    always_comb begin
        logic placed;
        st_d   = '0;
        placed = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src = (pick_any && (i >= int'(pick_idx))) ? i + 1 : i;
            if (src < DEPTH) begin
                st_d.vld[i]        = st_q.vld[src];
                st_d.ent[i].dst    = st_q.ent[src].dst;
                st_d.ent[i].r0     = wk_rdy[2*src];
                st_d.ent[i].f0     = wk_fld[2*src];
                st_d.ent[i].r1     = wk_rdy[2*src+1];
                st_d.ent[i].f1     = wk_fld[2*src+1];
            end
        end
        if (disp_valid && disp_ready && !flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !st_d.vld[i]) begin
                    placed          = 1'b1;
                    st_d.vld[i]     = 1'b1;
                    st_d.ent[i].dst = disp_dst;
                    st_d.ent[i].r0  = wk_rdy[DSRC];
                    st_d.ent[i].f0  = wk_fld[DSRC];
                    st_d.ent[i].r1  = wk_rdy[DSRC+1];
                    st_d.ent[i].f1  = wk_fld[DSRC+1];
                end
            end
        end
        if (flush) begin
            st_d.vld = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Occupied slots always form a contiguous prefix (age order, R6).
    p_packed_prefix_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.vld + 1'b1));

    // An issuing entry is occupied and has both sources ready (R3).
    p_issue_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (st_q.vld[pick_idx] && st_q.ent[pick_idx].r0 && st_q.ent[pick_idx].r1));

    // No older ready entry is passed over (R6).
    p_oldest_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ((req & ((DEPTH'(1) << pick_idx) - DEPTH'(1))) == '0));

    // Flush leaves the window empty on the next cycle (R7).
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.vld == '0));

    // A full window never grows (R8).
    p_full_no_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_ready |=> ($countones(st_q.vld) <= $past($countones(st_q.vld))));
endmodule

// File: tb/tb_issue_window.sv
`timescale 1ns/1ps
module tb_issue_window;
    localparam int DEPTH = 8;
    localparam int VW = 6;
    localparam int PW = 5;
    localparam int FW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic disp_valid = 1'b0;
    logic disp_rdy0 = 1'b0, disp_rdy1 = 1'b0;
    logic [FW-1:0] disp_fld0 = '0, disp_fld1 = '0;
    logic [VW-1:0] disp_dst = '0;
    logic disp_ready;
    logic bc_valid = 1'b0;
    logic [VW-1:0] bc_vtag = '0;
    logic [PW-1:0] bc_preg = '0;
    logic issue_valid;
    logic [PW-1:0] issue_src0, issue_src1;
    logic [VW-1:0] issue_dst;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    issue_window #(.DEPTH(DEPTH), .VTAG_W(VW), .PREG_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_rdy0(disp_rdy0), .disp_fld0(disp_fld0),
        .disp_rdy1(disp_rdy1), .disp_fld1(disp_fld1), .disp_dst(disp_dst),
        .disp_ready(disp_ready),
        .bc_valid(bc_valid), .bc_vtag(bc_vtag), .bc_preg(bc_preg),
        .issue_valid(issue_valid), .issue_src0(issue_src0),
        .issue_src1(issue_src1), .issue_dst(issue_dst)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        disp_valid = 1'b0;
        bc_valid   = 1'b0;
        flush      = 1'b0;
    endtask

    task automatic put(input logic r0, input int f0, input logic r1,
                       input int f1, input int dst);
        disp_valid = 1'b1;
        disp_rdy0  = r0;
        disp_fld0  = FW'(f0);
        disp_rdy1  = r1;
        disp_fld1  = FW'(f1);
        disp_dst   = VW'(dst);
    endtask

    task automatic bcast(input int tag, input int preg);
        bc_valid = 1'b1;
        bc_vtag  = VW'(tag);
        bc_preg  = PW'(preg);
    endtask

    task automatic t_reset();
        check("R1 issue_valid", int'(issue_valid), 0);
        check("R1 disp_ready", int'(disp_ready), 1);
    endtask

    task automatic t_ready_dispatch();
        put(1, 3, 1, 17, 40);
        step(); quiet();
        check("R2 valid", int'(issue_valid), 1);
        check("R2 src0", int'(issue_src0), 3);
        check("R2 src1", int'(issue_src1), 17);
        check("R2 dst", int'(issue_dst), 40);
        step();
        check("R2 gone", int'(issue_valid), 0);
    endtask

    task automatic t_wakeup();
        put(0, 4, 1, 4, 12);
        step(); quiet();
        check("R3 blocked", int'(issue_valid), 0);
        bcast(8, 9);
        step(); quiet();
        check("R4 nomatch", int'(issue_valid), 0);
        bcast(4, 11);
        step(); quiet();
        check("R3 valid", int'(issue_valid), 1);
        check("R3 src0 replaced", int'(issue_src0), 11);
        check("R9 src1 kept", int'(issue_src1), 4);
        check("R3 dst", int'(issue_dst), 12);
        step();
        check("R3 gone", int'(issue_valid), 0);
    endtask

    task automatic t_same_cycle();
        put(0, 21, 0, 22, 33);
        bcast(21, 6);
        step(); quiet();
        check("R5 still waits src1", int'(issue_valid), 0);
        bcast(22, 7);
        step(); quiet();
        check("R5 valid", int'(issue_valid), 1);
        check("R5 src0", int'(issue_src0), 6);
        check("R5 src1", int'(issue_src1), 7);
        step();
    endtask

    task automatic t_oldest();
        put(0, 30, 1, 1, 1);
        step();
        put(0, 30, 1, 2, 2);
        step(); quiet();
        bcast(30, 13);
        step(); quiet();
        check("R6 first", int'(issue_dst), 1);
        check("R6 first src0", int'(issue_src0), 13);
        step();
        check("R6 second valid", int'(issue_valid), 1);
        check("R6 second", int'(issue_dst), 2);
        step();
        check("R6 empty", int'(issue_valid), 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) begin
            put(0, 33, 1, i, 50 + i);
            step();
        end
        quiet();
        check("R8 not ready", int'(disp_ready), 0);
        put(1, 1, 1, 1, 63);
        step(); quiet();
        check("R8 ignored", int'(issue_valid), 0);
        bcast(33, 2);
        step(); quiet();
        for (int i = 0; i < DEPTH; i++) begin
            check("R6 order", int'(issue_dst), 50 + i);
            step();
        end
        check("R8 extra absent", int'(issue_valid), 0);
        check("R8 ready again", int'(disp_ready), 1);
    endtask

    task automatic t_flush();
        put(0, 40, 1, 0, 5);
        step();
        put(0, 40, 1, 0, 6);
        step(); quiet();
        flush = 1'b1;
        put(1, 1, 1, 1, 44);
        step(); quiet();
        check("R7 empty", int'(issue_valid), 0);
        check("R7 ready", int'(disp_ready), 1);
        bcast(40, 3);
        step(); quiet();
        check("R7 no revive", int'(issue_valid), 0);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_ready_dispatch();
        t_wakeup();
        t_same_cycle();
        t_oldest();
        t_full();
        t_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule